// File: doc/BRIEF.md
# Per-Core Interrupt Request Front-End

This block sits between the asynchronous, active-low interrupt request pins of a cluster and the exception logic of each core. Every pin is first brought into the core clock domain through a synchronizer that resets to the inactive (high) level. Normal, fast, virtual-normal and virtual-fast requests are treated as level-sensitive. Each one produces an active-high request to the core that follows the synchronized pin and drops only when the requester releases the pin. System-error, virtual system-error and RAM-error pins are edge-sensitive: a high-to-low transition sets a sticky pending bit, and a one-cycle acknowledge from that core clears it.

A static mode input selects where the level requests come from. With the mode input at 1, the internal controller CPU-interface path is bypassed and the raw legacy pins drive the core requests. With the mode input at 0, the requests come from the internal controller's active-low request inputs, and the external virtual pins are ignored. In that mode the internal controller also drives a per-core active-low maintenance interrupt output, which is held high in bypass mode. A 22-bit peripheral base address (address bits 39..18) is captured while reset is asserted and held afterwards.

The block has no data stream, so it has no valid/ready interface. All of its pins are plain control or status pins. Core index k always uses bit k of every per-core vector.

Top module: `irq_frontend`

## Requirements
- R1: In bypass mode (`bypass_ctl`=1), a 0 on a level pin (`irq_pin_n`, `fiq_pin_n`, `virq_pin_n`, `vfiq_pin_n`) bit k drives the matching `core_*` output bit k to 1 after exactly two rising clock edges. After the pin returns to 1, the output returns to 0 after the same two edges.
- R2: During and right after reset, all synchronizer stages read as inactive. Every `core_*` and `*_pend` output is 0 until a pin changes.
- R3: In bypass mode, the internal request inputs `ctl_irq_n`, `ctl_fiq_n`, `ctl_virq_n` and `ctl_vfiq_n` have no effect on `core_*`.
- R4: In internal mode (`bypass_ctl`=0), each `core_*` bit is the inverse of the matching `ctl_*_n` bit in the same cycle. All four external level pins, including the virtual ones, have no effect.
- R5: A high-to-low transition on `serr_pin_n`, `vserr_pin_n` or `ramerr_pin_n` bit k sets the matching `*_pend` bit k on the third rising edge after the pin falls.
- R6: A pending bit stays 1 until its acknowledge bit is 1 at a rising edge. It then reads 0 after that edge.
- R7: If a new falling edge is detected in the same cycle as the acknowledge, the pending bit stays 1.
- R8: An error pin that stays low, or that rises, creates no new event. After an acknowledge, a pin that is still low leaves the bit at 0.
- R9: `maint_irq_n` is all ones while `bypass_ctl`=1. Otherwise, bit k is the inverse of `ctl_maint_req` bit k.
- R10: `base_addr_o` takes the value of `base_addr_i` at each rising edge while `rst_n` is 0, and holds that value while `rst_n` is 1.
- R11: An event or acknowledge on core k, or in one error class, leaves every other core's and every other class's pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset; base address capture window |
| bypass_ctl | input | 1 | 1: legacy pins drive core requests; 0: internal controller drives them |
| base_addr_i | input | 22 | Peripheral base address bits 39..18 |
| base_addr_o | output | 22 | Captured peripheral base address |
| irq_pin_n | input | NUM_CORES | Normal interrupt pins, active low |
| fiq_pin_n | input | NUM_CORES | Fast interrupt pins, active low |
| virq_pin_n | input | NUM_CORES | Virtual normal interrupt pins, active low |
| vfiq_pin_n | input | NUM_CORES | Virtual fast interrupt pins, active low |
| serr_pin_n | input | NUM_CORES | System-error pins, falling edge |
| vserr_pin_n | input | NUM_CORES | Virtual system-error pins, falling edge |
| ramerr_pin_n | input | NUM_CORES | RAM-error pins, falling edge |
| ctl_irq_n | input | NUM_CORES | Internal controller normal request, active low |
| ctl_fiq_n | input | NUM_CORES | Internal controller fast request, active low |
| ctl_virq_n | input | NUM_CORES | Internal controller virtual normal request, active low |
| ctl_vfiq_n | input | NUM_CORES | Internal controller virtual fast request, active low |
| ctl_maint_req | input | NUM_CORES | Internal maintenance request, active high |
| serr_ack | input | NUM_CORES | System-error acknowledge pulse |
| vserr_ack | input | NUM_CORES | Virtual system-error acknowledge pulse |
| ramerr_ack | input | NUM_CORES | RAM-error acknowledge pulse |
| core_irq | output | NUM_CORES | Normal interrupt request to core |
| core_fiq | output | NUM_CORES | Fast interrupt request to core |
| core_virq | output | NUM_CORES | Virtual normal interrupt request to core |
| core_vfiq | output | NUM_CORES | Virtual fast interrupt request to core |
| serr_pend | output | NUM_CORES | System-error pending |
| vserr_pend | output | NUM_CORES | Virtual system-error pending |
| ramerr_pend | output | NUM_CORES | RAM-error pending |
| maint_irq_n | output | NUM_CORES | Maintenance interrupt, active low |

## Verification
Each kind of wrong internal state shows up at the ports in a fixed number of cycles.

- A stuck or miswired synchronizer stage changes the two-edge latency of the level outputs. The error is visible one cycle early or late, or never.
- A wrong edge-history flop either misses an event or raises one on a held or rising pin. A stuck history flop shows up three edges after the stimulus.
- A pending bit that loses its hold term drops one edge after it sets.
- A mishandled acknowledge collision clears a bit that should survive. The error shows on the edge after the acknowledge.
- Crossed per-core or per-class indexing shows at once, on a neighbouring bit of the output vectors.

// File: rtl/irq_frontend_pkg.sv
package irq_frontend_pkg;
  localparam int unsigned LVL_CLASSES = 4;
  localparam int unsigned ERR_CLASSES = 3;
  localparam int unsigned BASE_W      = 22;

  typedef enum logic [1:0] {
    LVL_IRQ  = 2'd0,
    LVL_FIQ  = 2'd1,
    LVL_VIRQ = 2'd2,
    LVL_VFIQ = 2'd3
  } lvl_class_e;

  typedef enum logic [1:0] {
    ERR_SYS  = 2'd0,
    ERR_VSYS = 2'd1,
    ERR_RAM  = 2'd2
  } err_class_e;
endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_n,
  output logic [WIDTH-1:0] q_n
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= d_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_n = chain[STAGES-1];

  // R2: the synchronized view is idle on the first edge after reset
  assert_sync_idle_R2: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_n == '1));
endmodule

// File: rtl/irqfe_edge_pend.sv
module irqfe_edge_pend #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_n,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] pend
);
  logic [WIDTH-1:0] hist_n;
  logic [WIDTH-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_n <= '1;
    else        hist_n <= sync_n;
  end

  assign fall = hist_n & ~sync_n;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend[b] <= 1'b0;
        else if (fall[b]) pend[b] <= 1'b1;
        else if (ack[b])  pend[b] <= 1'b0;
      end
    end
  endgenerate

  assert_set_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(fall)) == $past(fall));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(pend & ~ack)) == $past(pend & ~ack));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(ack & ~fall)) == '0);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(~pend & ~fall)) == '0);
endmodule

// File: rtl/irqfe_level_sel.sv
module irqfe_level_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             bypass,
  input  logic [WIDTH-1:0] pin_sync_n,
  input  logic [WIDTH-1:0] ctl_n,
  output logic [WIDTH-1:0] req
);
  always_comb begin
    if (bypass) req = ~pin_sync_n;
    else        req = ~ctl_n;
  end
endmodule

// File: rtl/irq_frontend.sv
module irq_frontend
  import irq_frontend_pkg::*;
#(
  parameter int unsigned NUM_CORES   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass_ctl,
  input  logic [BASE_W-1:0]    base_addr_i,
  output logic [BASE_W-1:0]    base_addr_o,
  input  logic [NUM_CORES-1:0] irq_pin_n,
  input  logic [NUM_CORES-1:0] fiq_pin_n,
  input  logic [NUM_CORES-1:0] virq_pin_n,
  input  logic [NUM_CORES-1:0] vfiq_pin_n,
  input  logic [NUM_CORES-1:0] serr_pin_n,
  input  logic [NUM_CORES-1:0] vserr_pin_n,
  input  logic [NUM_CORES-1:0] ramerr_pin_n,
  input  logic [NUM_CORES-1:0] ctl_irq_n,
  input  logic [NUM_CORES-1:0] ctl_fiq_n,
  input  logic [NUM_CORES-1:0] ctl_virq_n,
  input  logic [NUM_CORES-1:0] ctl_vfiq_n,
  input  logic [NUM_CORES-1:0] ctl_maint_req,
  input  logic [NUM_CORES-1:0] serr_ack,
  input  logic [NUM_CORES-1:0] vserr_ack,
  input  logic [NUM_CORES-1:0] ramerr_ack,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq,
  output logic [NUM_CORES-1:0] core_virq,
  output logic [NUM_CORES-1:0] core_vfiq,
  output logic [NUM_CORES-1:0] serr_pend,
  output logic [NUM_CORES-1:0] vserr_pend,
  output logic [NUM_CORES-1:0] ramerr_pend,
  output logic [NUM_CORES-1:0] maint_irq_n
);
  localparam int unsigned LVL_W = LVL_CLASSES * NUM_CORES;
  localparam int unsigned ERR_W = ERR_CLASSES * NUM_CORES;

  logic [LVL_W-1:0] lvl_pin_n, lvl_sync_n, lvl_ctl_n, lvl_req;
  logic [ERR_W-1:0] err_pin_n, err_sync_n, err_ack, err_pend;

  assign lvl_pin_n = {vfiq_pin_n, virq_pin_n, fiq_pin_n, irq_pin_n};
  assign lvl_ctl_n = {ctl_vfiq_n, ctl_virq_n, ctl_fiq_n, ctl_irq_n};
  assign err_pin_n = {ramerr_pin_n, vserr_pin_n, serr_pin_n};
  assign err_ack   = {ramerr_ack, vserr_ack, serr_ack};

  irqfe_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk(clk), .rst_n(rst_n), .d_n(lvl_pin_n), .q_n(lvl_sync_n));

  irqfe_sync #(.WIDTH(ERR_W), .STAGES(SYNC_STAGES)) u_err_sync (
    .clk(clk), .rst_n(rst_n), .d_n(err_pin_n), .q_n(err_sync_n));

  irqfe_level_sel #(.WIDTH(LVL_W)) u_lvl_sel (
    .bypass(bypass_ctl), .pin_sync_n(lvl_sync_n),
    .ctl_n(lvl_ctl_n), .req(lvl_req));

  irqfe_edge_pend #(.WIDTH(ERR_W)) u_err_pend (
    .clk(clk), .rst_n(rst_n), .sync_n(err_sync_n),
    .ack(err_ack), .pend(err_pend));

  assign core_irq  = lvl_req[int'(LVL_IRQ)*NUM_CORES  +: NUM_CORES];
  assign core_fiq  = lvl_req[int'(LVL_FIQ)*NUM_CORES  +: NUM_CORES];
  assign core_virq = lvl_req[int'(LVL_VIRQ)*NUM_CORES +: NUM_CORES];
  assign core_vfiq = lvl_req[int'(LVL_VFIQ)*NUM_CORES +: NUM_CORES];

  assign serr_pend   = err_pend[int'(ERR_SYS)*NUM_CORES  +: NUM_CORES];
  assign vserr_pend  = err_pend[int'(ERR_VSYS)*NUM_CORES +: NUM_CORES];
  assign ramerr_pend = err_pend[int'(ERR_RAM)*NUM_CORES  +: NUM_CORES];

  assign maint_irq_n = bypass_ctl ? '1 : ~ctl_maint_req;

  always_ff @(posedge clk) begin
    if (!rst_n) base_addr_o <= base_addr_i;
  end

  assert_maint_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_ctl |-> (maint_irq_n == '1));

  assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(base_addr_o));

  assert_level_from_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_ctl |-> ((core_virq & ctl_virq_n) == '0));
endmodule

// File: tb/sim_irq_frontend.sv
module sim_irq_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_ctl = 1'b1;
  logic [21:0] base_addr_i = 22'h2ABCDE;
  logic [21:0] base_addr_o;
  logic [N-1:0] irq_pin_n = '1, fiq_pin_n = '1, virq_pin_n = '1, vfiq_pin_n = '1;
  logic [N-1:0] serr_pin_n = '1, vserr_pin_n = '1, ramerr_pin_n = '1;
  logic [N-1:0] ctl_irq_n = '1, ctl_fiq_n = '1, ctl_virq_n = '1, ctl_vfiq_n = '1;
  logic [N-1:0] ctl_maint_req = '0;
  logic [N-1:0] serr_ack = '0, vserr_ack = '0, ramerr_ack = '0;
  logic [N-1:0] core_irq, core_fiq, core_virq, core_vfiq;
  logic [N-1:0] serr_pend, vserr_pend, ramerr_pend, maint_irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_frontend #(.NUM_CORES(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bypass_ctl(bypass_ctl),
    .base_addr_i(base_addr_i), .base_addr_o(base_addr_o),
    .irq_pin_n(irq_pin_n), .fiq_pin_n(fiq_pin_n),
    .virq_pin_n(virq_pin_n), .vfiq_pin_n(vfiq_pin_n),
    .serr_pin_n(serr_pin_n), .vserr_pin_n(vserr_pin_n),
    .ramerr_pin_n(ramerr_pin_n),
    .ctl_irq_n(ctl_irq_n), .ctl_fiq_n(ctl_fiq_n),
    .ctl_virq_n(ctl_virq_n), .ctl_vfiq_n(ctl_vfiq_n),
    .ctl_maint_req(ctl_maint_req),
    .serr_ack(serr_ack), .vserr_ack(vserr_ack), .ramerr_ack(ramerr_ack),
    .core_irq(core_irq), .core_fiq(core_fiq),
    .core_virq(core_virq), .core_vfiq(core_vfiq),
    .serr_pend(serr_pend), .vserr_pend(vserr_pend),
    .ramerr_pend(ramerr_pend), .maint_irq_n(maint_irq_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    base_addr_i = 22'h2ABCDE;
    step(3);
    check("R2 level outputs in reset", {core_irq, core_fiq, core_virq, core_vfiq}, 0);
    check("R2 pending in reset", {serr_pend, vserr_pend, ramerr_pend}, 0);
    check("R10 base captured in reset", base_addr_o, 22'h2ABCDE);
    rst_n = 1'b1;
    step(1);
    check("R2 outputs idle after reset", {core_irq, core_fiq, serr_pend, ramerr_pend}, 0);
  endtask

  task automatic t_base();
    base_addr_i = 22'h015A5A;
    step(4);
    check("R10 base held after reset", base_addr_o, 22'h2ABCDE);
    rst_n = 1'b0;
    step(1);
    check("R10 base recaptured in reset", base_addr_o, 22'h015A5A);
    rst_n = 1'b1;
    base_addr_i = 22'h3FFFFF;
    step(2);
    check("R10 base held second time", base_addr_o, 22'h015A5A);
  endtask

  task automatic t_bypass_level();
    bypass_ctl = 1'b1;
    ctl_fiq_n = 2'b00;
    irq_pin_n = 2'b10;
    vfiq_pin_n = 2'b01;
    step(1);
    check("R1 level not yet through after one edge", core_irq, 0);
    step(1);
    check("R1 irq asserted after two edges", core_irq, 2'b01);
    check("R1 vfiq asserted core1", core_vfiq, 2'b10);
    check("R3 ctl fiq ignored in bypass", core_fiq, 0);
    irq_pin_n = 2'b11;
    vfiq_pin_n = 2'b11;
    step(1);
    check("R1 irq still held one edge after release", core_irq, 2'b01);
    step(1);
    check("R1 irq dropped after release", core_irq, 0);
    ctl_fiq_n = 2'b11;
  endtask

  task automatic t_internal_level();
    bypass_ctl = 1'b0;
    virq_pin_n = 2'b00;
    irq_pin_n = 2'b00;
    ctl_virq_n = 2'b10;
    ctl_vfiq_n = 2'b01;
    #1;
    check("R4 virq follows ctl", core_virq, 2'b01);
    check("R4 vfiq follows ctl", core_vfiq, 2'b10);
    step(3);
    ctl_virq_n = 2'b11;
    #1;
    check("R4 virq pins ignored internal", core_virq, 0);
    check("R4 irq pins ignored internal", core_irq, 0);
    virq_pin_n = 2'b11;
    irq_pin_n = 2'b11;
    ctl_vfiq_n = 2'b11;
    step(3);
    bypass_ctl = 1'b1;
  endtask

  task automatic t_edge_basic();
    serr_pin_n = 2'b01;
    step(2);
    check("R5 not pending after two edges", serr_pend, 0);
    step(1);
    check("R5 pending on third edge", serr_pend, 2'b10);
    step(5);
    check("R6 pending sticky while pin low", serr_pend, 2'b10);
    serr_ack = 2'b10;
    step(1);
    serr_ack = 2'b00;
    check("R6 ack clears pending", serr_pend, 0);
    step(4);
    check("R8 held low does not re-arm", serr_pend, 0);
    serr_pin_n = 2'b11;
    step(4);
    check("R8 rising edge gives no event", serr_pend, 0);
  endtask

  task automatic t_collision();
    ramerr_pin_n = 2'b10;
    step(3);
    check("R5 ram error pending", ramerr_pend, 2'b01);
    ramerr_pin_n = 2'b11;
    step(3);
    ramerr_pin_n = 2'b10;
    step(2);
    ramerr_ack = 2'b01;
    step(1);
    ramerr_ack = 2'b00;
    check("R7 new edge with ack keeps pending", ramerr_pend, 2'b01);
    ramerr_ack = 2'b01;
    step(1);
    ramerr_ack = 2'b00;
    check("R6 later ack clears", ramerr_pend, 0);
    ramerr_pin_n = 2'b11;
    step(3);
  endtask

  task automatic t_isolation();
    vserr_pin_n = 2'b10;
    step(3);
    check("R11 only core0 vserr pending", vserr_pend, 2'b01);
    check("R11 other classes untouched", {serr_pend, ramerr_pend}, 0);
    vserr_ack = 2'b10;
    serr_ack = 2'b01;
    step(1);
    vserr_ack = 2'b00;
    serr_ack = 2'b00;
    check("R11 other core ack leaves pending", vserr_pend, 2'b01);
    vserr_ack = 2'b01;
    step(1);
    vserr_ack = 2'b00;
    check("R6 vserr ack clears", vserr_pend, 0);
    vserr_pin_n = 2'b11;
    step(3);
  endtask

  task automatic t_maint();
    bypass_ctl = 1'b1;
    ctl_maint_req = 2'b11;
    #1;
    check("R9 maint high in bypass", maint_irq_n, 2'b11);
    bypass_ctl = 1'b0;
    #1;
    check("R9 maint both asserted internal", maint_irq_n, 2'b00);
    ctl_maint_req = 2'b01;
    #1;
    check("R9 maint core0 only", maint_irq_n, 2'b10);
    ctl_maint_req = 2'b00;
    bypass_ctl = 1'b1;
    step(1);
  endtask

  initial begin
    t_reset();
    t_bypass_level();
    t_internal_level();
    t_edge_basic();
    t_collision();
    t_isolation();
    t_maint();
    t_base();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule